// File: doc/BRIEF.md
# Secondary Interrupt Controller with Line Passthrough

This block collects 32 level-sensitive interrupt requests and offers them to a primary controller in two ways. Every input is captured each clock into a raw level register. The raw levels, gated by a software enable mask, are ORed into one summary request. That request is driven on output line 31. Separately, each of lines 21 to 30 can be routed straight to its own output when its passthrough-enable bit is set. The primary controller can then take those lines without the summary.

Software reaches the block over a simple single-cycle bus. The bus has a valid strobe, a write flag, a 12-bit byte address and 32-bit data. The address selects one of 1024 words in a 4 KB window. The word index is the byte address with its two low bits dropped. Set and clear words modify the enable mask and the passthrough-enable register. Read words return masked status, raw level, the mask, bit 0 of the raw level and the passthrough-enable register. Every output is registered.

Top module: `sec_irq_ctrl`

## Requirements
- R1: Each clock, the raw level register captures `irq_in`. A read of word 1 returns the raw level as it stood in the access cycle.
- R2: `irq_out[31]` is high exactly when (raw level AND enable mask) is nonzero. It follows an input or mask change one clock later.
- R3: A read is a cycle with `bus_valid` high and `bus_write` low. The word index is `bus_addr[11:2]`, and `bus_addr[1:0]` is ignored. `bus_rdata` carries the read result in the cycle after the access and is zero after any cycle that is not a read. Word 0 reads raw level AND mask, word 1 reads the raw level, word 2 reads the mask and word 8 reads the passthrough-enable register.
- R4: A write to word 2 ORs the write data into the enable mask. A write to word 3 clears every mask bit that is set in the write data.
- R5: A read of word 4 returns raw level bit 0 in data bit 0, with the other bits zero. A write of nonzero data to word 4 sets mask bit 0, and a nonzero write to word 5 clears it. A write of zero to either word changes nothing.
- R6: A write to word 8 ORs (write data AND 0x7FE00000) into the passthrough-enable register, so only bits 21 to 30 can ever be set. A write to word 9 clears the bits given in the write data.
- R7: For lines 21 to 30, `irq_out[i]` equals raw level bit i AND passthrough-enable bit i, one clock after the cause. It is low when the enable bit is clear. Outputs 0 to 20 are always low.
- R8: A read of any word other than 0, 1, 2, 4 and 8 returns zero. A write to any word other than 2, 3, 4, 5, 8 and 9 has no effect.
- R9: An active-low asynchronous reset clears the raw level, the mask, the passthrough-enable register, `irq_out` and `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Level-sensitive interrupt requests |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq_out | output | 32 | Bit 31 summary, bits 21..30 passthrough, others low |

## Verification
The bench builds the block with its default parameters: a 12-bit address, passthrough range 21 to 30 and summary on line 31. With these values, every one of the 1024 word indices can be addressed, so undefined words far above word 9 get exercised as well as the gaps at 3, 5, 6 and 7. The passthrough edges at lines 20, 21, 30 and 31 sit next to the summary bit, which shows whether the range mask and the summary line are kept apart.

// File: rtl/sic_pkg.sv
package sic_pkg;

    localparam int SIC_W = 32;

    // word indices whose meaning the software side depends on
    localparam int SIC_WORD_STAT    = 0;
    localparam int SIC_WORD_RAW     = 1;
    localparam int SIC_WORD_EN_SET  = 2;
    localparam int SIC_WORD_EN_CLR  = 3;
    localparam int SIC_WORD_SW_SET  = 4;
    localparam int SIC_WORD_SW_CLR  = 5;
    localparam int SIC_WORD_PT_SET  = 8;
    localparam int SIC_WORD_PT_CLR  = 9;

    typedef struct packed {
        logic stat;
        logic raw;
        logic en_set;
        logic en_clr;
        logic sw_set;
        logic sw_clr;
        logic pt_set;
        logic pt_clr;
    } sic_sel_t;

    typedef struct packed {
        logic [SIC_W-1:0] level;
        logic [SIC_W-1:0] mask;
        logic [SIC_W-1:0] pten;
    } sic_state_t;

    function automatic logic [SIC_W-1:0] sic_range_mask(input int lo, input int hi);
        logic [SIC_W-1:0] m;
        for (int i = 0; i < SIC_W; i++) begin
            m[i] = (i >= lo) && (i <= hi);
        end
        return m;
    endfunction

endpackage

// File: rtl/sic_regs.sv
module sic_regs
    import sic_pkg::*;
#(
    parameter int PT_LO = 21,
    parameter int PT_HI = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SIC_W-1:0] irq_in,
    input  logic             wr_en,
    input  sic_sel_t         sel,
    input  logic [SIC_W-1:0] wdata,
    output sic_state_t       st_d_o,
    output sic_state_t       st_q_o
);

    localparam logic [SIC_W-1:0] PT_MASK = sic_range_mask(PT_LO, PT_HI);

    sic_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.level = irq_in;
        if (wr_en) begin
            if (sel.en_set) st_d.mask = st_q.mask | wdata;
            if (sel.en_clr) st_d.mask = st_q.mask & ~wdata;
            if (sel.sw_set && (wdata != '0)) st_d.mask[0] = 1'b1;
            if (sel.sw_clr && (wdata != '0)) st_d.mask[0] = 1'b0;
            if (sel.pt_set) st_d.pten = st_q.pten | (wdata & PT_MASK);
            if (sel.pt_clr) st_d.pten = st_q.pten & ~wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st_d_o = st_d;
    assign st_q_o = st_q;

    // R1
    level_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> st_q.level == $past(irq_in));

    // R4
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel.en_set) |=> (st_q.mask & $past(wdata)) == $past(wdata));

    // R4
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel.en_clr) |=> (st_q.mask & $past(wdata)) == '0);

    // R6
    pt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pten & ~PT_MASK) == '0);

endmodule

// File: rtl/sic_outs.sv
module sic_outs
    import sic_pkg::*;
#(
    parameter int PT_LO   = 21,
    parameter int PT_HI   = 30,
    parameter int SUM_IDX = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sic_state_t       st_d,
    output logic [SIC_W-1:0] irq_out
);

    logic [SIC_W-1:0] out_d, out_q;
    logic             sum_d;

    assign sum_d = |(st_d.level & st_d.mask);

    for (genvar i = 0; i < SIC_W; i++) begin : g_line
        if (i == SUM_IDX) begin : g_sum
            assign out_d[i] = sum_d;
        end else if ((i >= PT_LO) && (i <= PT_HI)) begin : g_pass
            assign out_d[i] = st_d.pten[i] & st_d.level[i];
        end else begin : g_idle
            assign out_d[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign irq_out = out_q;

endmodule

// File: rtl/sic_rdata.sv
module sic_rdata
    import sic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  sic_sel_t         sel,
    input  sic_state_t       st_q,
    output logic [SIC_W-1:0] rdata
);

    logic [SIC_W-1:0] rdata_d, rdata_q;
    logic             known;

    assign known = sel.stat | sel.raw | sel.en_set | sel.sw_set | sel.pt_set;

    always_comb begin
        rdata_d = '0;
        if (rd_en) begin
            if (sel.stat)   rdata_d = st_q.level & st_q.mask;
            if (sel.raw)    rdata_d = st_q.level;
            if (sel.en_set) rdata_d = st_q.mask;
            if (sel.sw_set) rdata_d = {{(SIC_W-1){1'b0}}, st_q.level[0]};
            if (sel.pt_set) rdata_d = st_q.pten;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

    // R8
    undef_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !known) |=> rdata == '0);

    // R3
    raw_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel.raw) |=> rdata == $past(st_q.level));

    // R3
    idle_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> rdata == '0);

endmodule

// File: rtl/sec_irq_ctrl.sv
module sec_irq_ctrl
    import sic_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int PT_LO   = 21,
    parameter int PT_HI   = 30,
    parameter int SUM_IDX = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SIC_W-1:0] irq_in,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [SIC_W-1:0] bus_wdata,
    output logic [SIC_W-1:0] bus_rdata,
    output logic [SIC_W-1:0] irq_out
);

    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] WD_STAT   = WORD_W'(SIC_WORD_STAT);
    localparam logic [WORD_W-1:0] WD_RAW    = WORD_W'(SIC_WORD_RAW);
    localparam logic [WORD_W-1:0] WD_EN_SET = WORD_W'(SIC_WORD_EN_SET);
    localparam logic [WORD_W-1:0] WD_EN_CLR = WORD_W'(SIC_WORD_EN_CLR);
    localparam logic [WORD_W-1:0] WD_SW_SET = WORD_W'(SIC_WORD_SW_SET);
    localparam logic [WORD_W-1:0] WD_SW_CLR = WORD_W'(SIC_WORD_SW_CLR);
    localparam logic [WORD_W-1:0] WD_PT_SET = WORD_W'(SIC_WORD_PT_SET);
    localparam logic [WORD_W-1:0] WD_PT_CLR = WORD_W'(SIC_WORD_PT_CLR);
    localparam logic [SIC_W-1:0]  PT_MASK   = sic_range_mask(PT_LO, PT_HI);
    localparam logic [SIC_W-1:0]  SUM_BIT   = sic_range_mask(SUM_IDX, SUM_IDX);

    logic [WORD_W-1:0] word;
    logic              wr_en, rd_en;
    sic_sel_t          sel;
    sic_state_t        st_d, st_q;

    assign word  = bus_addr[ADDR_W-1:2];
    assign wr_en = bus_valid & bus_write;
    assign rd_en = bus_valid & ~bus_write;

    always_comb begin
        sel = '0;
        case (word)
            WD_STAT:   sel.stat   = 1'b1;
            WD_RAW:    sel.raw    = 1'b1;
            WD_EN_SET: sel.en_set = 1'b1;
            WD_EN_CLR: sel.en_clr = 1'b1;
            WD_SW_SET: sel.sw_set = 1'b1;
            WD_SW_CLR: sel.sw_clr = 1'b1;
            WD_PT_SET: sel.pt_set = 1'b1;
            WD_PT_CLR: sel.pt_clr = 1'b1;
            default:   sel        = '0;
        endcase
    end

    sic_regs #(.PT_LO(PT_LO), .PT_HI(PT_HI)) i_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_in (irq_in),
        .wr_en  (wr_en),
        .sel    (sel),
        .wdata  (bus_wdata),
        .st_d_o (st_d),
        .st_q_o (st_q)
    );

    sic_outs #(.PT_LO(PT_LO), .PT_HI(PT_HI), .SUM_IDX(SUM_IDX)) i_outs (
        .clk     (clk),
        .rst_n   (rst_n),
        .st_d    (st_d),
        .irq_out (irq_out)
    );

    sic_rdata i_rdata (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_en (rd_en),
        .sel   (sel),
        .st_q  (st_q),
        .rdata (bus_rdata)
    );

    // R2
    summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out[SUM_IDX] == |(st_q.level & st_q.mask));

    // R7
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & PT_MASK) == (st_q.level & st_q.pten));

    // R7
    quiet_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & ~(PT_MASK | SUM_BIT)) == '0);

endmodule

// File: tb/test_sec_irq_ctrl.sv
module test_sec_irq_ctrl;

    localparam logic [31:0] PTM = 32'h7FE0_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] m_level = '0, m_mask = '0, m_pten = '0;

    always #2.5 clk = ~clk;

    sec_irq_ctrl i_sec_irq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    function automatic logic [31:0] rd_fn(input int w);
        case (w)
            0:       return m_level & m_mask;
            1:       return m_level;
            2:       return m_mask;
            4:       return {31'b0, m_level[0]};
            8:       return m_pten;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] out_fn();
        logic [31:0] o;
        o     = m_level & m_pten & PTM;
        o[31] = |(m_level & m_mask);
        return o;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic op(input string tag, input bit v, input bit w, input int word,
                      input logic [31:0] wd, input logic [31:0] irq, input logic [1:0] lo);
        logic [31:0] exp_rd;
        exp_rd    = (v && !w) ? rd_fn(word) : 32'h0;
        bus_valid = v;
        bus_write = w;
        bus_addr  = {word[9:0], lo};
        bus_wdata = wd;
        irq_in    = irq;
        @(posedge clk);
        m_level = irq;
        if (v && w) begin
            case (word)
                2: m_mask = m_mask | wd;
                3: m_mask = m_mask & ~wd;
                4: if (wd != 0) m_mask[0] = 1'b1;
                5: if (wd != 0) m_mask[0] = 1'b0;
                8: m_pten = m_pten | (wd & PTM);
                9: m_pten = m_pten & ~wd;
                default: ;
            endcase
        end
        @(negedge clk);
        chk({tag, " irq_out"}, irq_out, out_fn());
        chk({tag, " rdata"}, bus_rdata, exp_rd);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: got hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 reset irq_out", irq_out, 32'h0);
        chk("R9 reset rdata", bus_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        op("R9 mask after reset", 1, 0, 2, 0, 32'h0, 0);
        op("R9 pten after reset", 1, 0, 8, 0, 32'h0, 0);
        // R1 raw level
        op("R1 drive", 0, 0, 0, 0, 32'hA5A5_0001, 0);
        op("R1 raw read", 1, 0, 1, 0, 32'hA5A5_0001, 0);
        // R2 / R4 mask and summary
        op("R2 R4 en set", 1, 1, 2, 32'h0000_0F00, 32'h0000_0100, 0);
        op("R3 masked read", 1, 0, 0, 0, 32'h0000_0100, 0);
        op("R2 input drop", 0, 0, 0, 0, 32'h0, 0);
        op("R2 input rise", 0, 0, 0, 0, 32'h0000_0800, 0);
        op("R4 en clr", 1, 1, 3, 32'h0000_0800, 32'h0000_0800, 0);
        op("R4 mask read", 1, 0, 2, 0, 32'h0000_0800, 0);
        // R3 low address bits ignored
        op("R3 addr lo bits", 1, 0, 2, 0, 32'h0, 2'b11);
        // R5 soft word
        op("R5 zero set", 1, 1, 4, 32'h0, 32'h1, 0);
        op("R5 set", 1, 1, 4, 32'h8000_0000, 32'h1, 0);
        op("R5 bit0 read", 1, 0, 4, 0, 32'h1, 0);
        op("R5 zero clr", 1, 1, 5, 32'h0, 32'h1, 0);
        op("R5 clr", 1, 1, 5, 32'h2, 32'h1, 0);
        // R6 passthrough enable
        op("R6 pt set all", 1, 1, 8, 32'hFFFF_FFFF, 32'h0, 0);
        op("R6 pt read", 1, 0, 8, 0, 32'h0, 0);
        // R7 passthrough outputs at range edges
        op("R7 edges", 0, 0, 0, 0, 32'hC030_0000, 0);
        op("R6 R7 pt clr", 1, 1, 9, 32'h4000_0000, 32'hC030_0000, 0);
        op("R7 disabled low", 0, 0, 0, 0, 32'hFFFF_FFFF, 0);
        // R8 undefined words
        op("R8 wr w6", 1, 1, 6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
        op("R8 wr w0", 1, 1, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
        op("R8 wr w1023", 1, 1, 1023, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
        op("R8 mask kept", 1, 0, 2, 0, 32'hFFFF_FFFF, 0);
        op("R8 pten kept", 1, 0, 8, 0, 32'hFFFF_FFFF, 0);
        op("R8 rd w3", 1, 0, 3, 0, 32'hFFFF_FFFF, 0);
        op("R8 rd w9", 1, 0, 9, 0, 32'hFFFF_FFFF, 0);
        op("R8 rd w1023", 1, 0, 1023, 0, 32'hFFFF_FFFF, 0);
        // random mix
        for (int k = 0; k < 3000; k++) begin
            int          w;
            logic [31:0] wd;
            int          kind;
            kind = $urandom % 3;
            w    = ($urandom % 16 == 0) ? int'($urandom % 1024) : int'($urandom % 12);
            wd   = ($urandom % 4 == 0) ? 32'h0 : $urandom;
            op("R1-random R2 R3 R7", kind != 0, kind == 2, w, wd, $urandom, 2'($urandom));
        end
        // R9 reset in mid-run
        op("R9 pre", 1, 1, 2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
        rst_n = 1'b0;
        bus_valid = 1'b0;
        #1;
        chk("R9 async irq_out", irq_out, 32'h0);
        chk("R9 async rdata", bus_rdata, 32'h0);
        @(negedge clk);
        m_level = '0; m_mask = '0; m_pten = '0;
        irq_in = '0;
        rst_n = 1'b1;
        op("R9 mask cleared", 1, 0, 2, 0, 32'hFFFF_FFFF, 0);
        op("R9 pten cleared", 1, 0, 8, 0, 32'hFFFF_FFFF, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule